// File: doc/BRIEF.md
# Sensor Power-State and Clock-Gating Controller

This block governs the power states of an image-sensor control core. It runs on the master clock and takes an active-low hardware reset, an active-high standby pin, and a word-wide control register written over the two-wire serial interface. From these it produces three things:
- clock enables for the analog readout (the sensor clock) and for the image pipeline (the pixel clock),
- a one-cycle soft-reset pulse,
- the enable for the data output pins and the effective serial device address.

A standby request can come from the pin or from a register bit. Such a request is not acted on at once. The block keeps the clocks running until the readout sequencer reports that the current row is done, and only then stops them. The hardware reset asserts asynchronously and releases through a two-flop synchronizer. The standby pin is also synchronized through two flops before any logic uses it.

Top module: `sns_pwr_ctrl`

## Requirements
- R1: After reset, the control word is all zeros. The outputs are then: `out_en_o`=1, `soft_rst_o`=0, `stby_pending_o`=0, `stby_active_o`=0, and `dev_addr_o` = {BASE_ADDR[ADDR_W-1:1], `strap_i`}.
- R2: A write with bit 0 set loads the default value (all zeros) into every control field. `soft_rst_o` is then high for exactly the one cycle after the write edge.
- R3: Control bit 3 selects the master-clock halving. With bit 3 = 0, `sns_clk_en_o` is high on every running cycle. With bit 3 = 1, it is high on every second running cycle.
- R4: `pix_clk_en_o` is high on every second `sns_clk_en_o` pulse. It is never high on two consecutive cycles.
- R5: When control bit 1 is set, `pix_clk_en_o` stays low and `sns_clk_en_o` keeps running.
- R6: A standby request is the synchronized pin or control bit 2. It first raises `stby_pending_o`, and the clocks keep running. Standby becomes active only on the edge where `row_done_i` is high. While standby is active, both clock enables are low.
- R7: If the request drops while pending, the block returns to running without entering standby.
- R8: If the request clears while standby is active, `stby_active_o` falls on the next edge and the clocks resume.
- R9: `out_en_o` is low when control bit 4 is 1. It is also low when the synchronized pin is 1 and control bit 6 is 0. Otherwise it is high. Soft standby (bit 2) alone does not affect it.
- R10: `dev_addr_o` bit 0 equals `strap_i` XOR control bit 10. While the synchronized pin is high, writes leave bit 10 unchanged, but the other bits in the same write still take effect.
- R11: A change on `stby_pin_i` reaches the pin-dependent logic after two master-clock edges. The standby state machine reacts on the third edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Hardware reset, active low, asynchronous assert |
| stby_pin_i | input | 1 | Standby pin, active high, asynchronous |
| reg_we_i | input | 1 | Control register write strobe |
| reg_wdata_i | input | CTRL_W | Control register write data |
| row_done_i | input | 1 | Current row readout finished |
| strap_i | input | 1 | Address strap |
| sns_clk_en_o | output | 1 | Sensor/analog clock enable |
| pix_clk_en_o | output | 1 | Pixel pipeline clock enable |
| soft_rst_o | output | 1 | Soft-reset pulse |
| out_en_o | output | 1 | Data output pin drive enable |
| dev_addr_o | output | ADDR_W | Effective serial device address |
| stby_pending_o | output | 1 | Standby requested, waiting for row end |
| stby_active_o | output | 1 | Standby in effect, clocks stopped |

## Verification
The bench builds the block with CTRL_W=16, ADDR_W=7 and BASE_ADDR=7'h48. These values give bit 10 a real field to occupy, and they make the reset address 7'h49 and the flipped address 7'h48, which are easy to tell apart. With these widths, every control field, both halving settings and the bit 10 lock can be reached by writing a single word. The bench counts enable pulses over fixed windows and compares them with the rate that the settings call for. It also times the pin synchronizer and the row-gated standby entry edge by edge.

// File: rtl/sns_pwr_pkg.sv
package sns_pwr_pkg;
  // control word field positions
  localparam int unsigned SRST_BIT     = 0;
  localparam int unsigned PIPE_OFF_BIT = 1;
  localparam int unsigned SSTBY_BIT    = 2;
  localparam int unsigned DIV2_BIT     = 3;
  localparam int unsigned ODIS_BIT     = 4;
  localparam int unsigned DRIVE_BIT    = 6;
  localparam int unsigned AFLIP_BIT    = 10;

  typedef enum logic [1:0] {
    PS_RUN  = 2'd0,
    PS_PEND = 2'd1,
    PS_STBY = 2'd2
  } pwr_state_e;
endpackage

// File: rtl/sns_sync2.sv
module sns_sync2 #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/sns_ctrl_regs.sv
module sns_ctrl_regs
  import sns_pwr_pkg::*;
#(
  parameter int unsigned CTRL_W  = 16,
  parameter logic [CTRL_W-1:0] DEFAULT = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  input  logic              flip_lock_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              srst_o
);
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic              srst_q, srst_d;

  always_comb begin
    ctrl_d = ctrl_q;
    srst_d = 1'b0;
    if (we_i) begin
      if (wdata_i[SRST_BIT]) begin
        ctrl_d = DEFAULT;
        srst_d = 1'b1;
      end else begin
        ctrl_d = wdata_i;
        if (flip_lock_i) ctrl_d[AFLIP_BIT] = ctrl_q[AFLIP_BIT];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= DEFAULT;
      srst_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      srst_q <= srst_d;
    end
  end

  assign ctrl_o = ctrl_q;
  assign srst_o = srst_q;
endmodule

// File: rtl/sns_stby_fsm.sv
module sns_stby_fsm
  import sns_pwr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic row_done_i,
  output logic pending_o,
  output logic active_o
);
  pwr_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PS_RUN:  if (req_i) state_d = PS_PEND;
      PS_PEND: begin
        if (!req_i)          state_d = PS_RUN;
        else if (row_done_i) state_d = PS_STBY;
      end
      PS_STBY: if (!req_i) state_d = PS_RUN;
      default: state_d = PS_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= PS_RUN;
    else         state_q <= state_d;
  end

  assign pending_o = (state_q == PS_PEND);
  assign active_o  = (state_q == PS_STBY);
endmodule

// File: rtl/sns_clk_gen.sv
module sns_clk_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic div2_i,
  input  logic pipe_off_i,
  output logic sns_en_o,
  output logic pix_en_o
);
  logic div_ph_q, div_ph_d;
  logic pix_ph_q, pix_ph_d;
  logic tick;

  assign tick = !div2_i || div_ph_q;

  always_comb begin
    div_ph_d = !div_ph_q;
    pix_ph_d = pix_ph_q;
    if (run_i && tick) pix_ph_d = !pix_ph_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_ph_q <= 1'b0;
      pix_ph_q <= 1'b0;
    end else begin
      div_ph_q <= div_ph_d;
      pix_ph_q <= pix_ph_d;
    end
  end

  assign sns_en_o = run_i && tick;
  assign pix_en_o = run_i && tick && pix_ph_q && !pipe_off_i;
endmodule

// File: rtl/sns_pwr_ctrl.sv
module sns_pwr_ctrl
  import sns_pwr_pkg::*;
#(
  parameter int unsigned CTRL_W = 16,
  parameter int unsigned ADDR_W = 7,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 7'h48
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stby_pin_i,
  input  logic              reg_we_i,
  input  logic [CTRL_W-1:0] reg_wdata_i,
  input  logic              row_done_i,
  input  logic              strap_i,
  output logic              sns_clk_en_o,
  output logic              pix_clk_en_o,
  output logic              soft_rst_o,
  output logic              out_en_o,
  output logic [ADDR_W-1:0] dev_addr_o,
  output logic              stby_pending_o,
  output logic              stby_active_o
);
  localparam logic [CTRL_W-1:0] CTRL_DEFAULT = '0;

  logic              rst_n_int;
  logic              stby_sync;
  logic [CTRL_W-1:0] ctrl_q;
  logic              req;

  sns_sync2 #(.RST_VAL(1'b0)) u_rst_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(1'b1), .q_o(rst_n_int)
  );

  sns_sync2 #(.RST_VAL(1'b0)) u_pin_sync (
    .clk_i(clk_i), .rst_ni(rst_n_int), .d_i(stby_pin_i), .q_o(stby_sync)
  );

  sns_ctrl_regs #(.CTRL_W(CTRL_W), .DEFAULT(CTRL_DEFAULT)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_n_int), .we_i(reg_we_i), .wdata_i(reg_wdata_i),
    .flip_lock_i(stby_sync), .ctrl_o(ctrl_q), .srst_o(soft_rst_o)
  );

  assign req = stby_sync || ctrl_q[SSTBY_BIT];

  sns_stby_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_n_int), .req_i(req), .row_done_i(row_done_i),
    .pending_o(stby_pending_o), .active_o(stby_active_o)
  );

  sns_clk_gen u_clk (
    .clk_i(clk_i), .rst_ni(rst_n_int), .run_i(!stby_active_o),
    .div2_i(ctrl_q[DIV2_BIT]), .pipe_off_i(ctrl_q[PIPE_OFF_BIT]),
    .sns_en_o(sns_clk_en_o), .pix_en_o(pix_clk_en_o)
  );

  assign out_en_o   = !ctrl_q[ODIS_BIT] && !(stby_sync && !ctrl_q[DRIVE_BIT]);
  assign dev_addr_o = {BASE_ADDR[ADDR_W-1:1], strap_i ^ ctrl_q[AFLIP_BIT]};
endmodule

// File: rtl/sns_pwr_ctrl_chk.sv
module sns_pwr_ctrl_chk #(
  parameter int unsigned CTRL_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stby_sync,
  input logic              flip_q,
  input logic              req,
  input logic              reg_we_i,
  input logic [CTRL_W-1:0] reg_wdata_i,
  input logic              row_done_i,
  input logic              sns_clk_en_o,
  input logic              pix_clk_en_o,
  input logic              soft_rst_o,
  input logic              stby_pending_o,
  input logic              stby_active_o
);
  // R2: the soft-reset pulse lasts a single cycle
  p_srst_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_o |=> !soft_rst_o);

  // R4: pixel enable never on two cycles in a row
  p_pix_half_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pix_clk_en_o |=> !pix_clk_en_o);

  // R4: pixel enable only coincides with a sensor tick
  p_pix_in_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pix_clk_en_o |-> sns_clk_en_o);

  // R6: clocks held off throughout standby
  p_stby_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stby_active_o |-> (!sns_clk_en_o && !pix_clk_en_o));

  // R6: standby entered only from pending with row done
  p_entry_row_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stby_active_o) |-> ($past(stby_pending_o) && $past(row_done_i)));

  // R6: pending and active never together
  p_state_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stby_pending_o, stby_active_o}));

  // R8: request withdrawn in standby leaves it on the next edge
  p_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stby_active_o && !req) |=> !stby_active_o);

  // R10: address flip bit locked while the pin is high
  p_flip_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stby_sync && !(reg_we_i && reg_wdata_i[0])) |=> $stable(flip_q));
endmodule

bind sns_pwr_ctrl sns_pwr_ctrl_chk #(.CTRL_W(CTRL_W)) u_chk (
  .clk(clk_i), .rst_n(rst_n_int), .stby_sync(stby_sync),
  .flip_q(ctrl_q[sns_pwr_pkg::AFLIP_BIT]), .req(req),
  .reg_we_i(reg_we_i), .reg_wdata_i(reg_wdata_i), .row_done_i(row_done_i),
  .sns_clk_en_o(sns_clk_en_o), .pix_clk_en_o(pix_clk_en_o),
  .soft_rst_o(soft_rst_o), .stby_pending_o(stby_pending_o),
  .stby_active_o(stby_active_o)
);

// File: tb/tb_sns_pwr_ctrl.sv
module tb_sns_pwr_ctrl;
  localparam int unsigned CTRL_W = 16;
  localparam int unsigned ADDR_W = 7;
  localparam logic [ADDR_W-1:0] BASE = 7'h48;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin = 1'b0;
  logic we = 1'b0;
  logic [CTRL_W-1:0] wdata = '0;
  logic row_done = 1'b0;
  logic strap = 1'b1;
  logic sns_en, pix_en, srst, oe, pend, act;
  logic [ADDR_W-1:0] addr;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sns_pwr_ctrl #(.CTRL_W(CTRL_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE)) dut (
    .clk_i(clk), .rst_ni(rst_n), .stby_pin_i(pin), .reg_we_i(we),
    .reg_wdata_i(wdata), .row_done_i(row_done), .strap_i(strap),
    .sns_clk_en_o(sns_en), .pix_clk_en_o(pix_en), .soft_rst_o(srst),
    .out_en_o(oe), .dev_addr_o(addr), .stby_pending_o(pend),
    .stby_active_o(act)
  );

  task automatic check(input string req, input int act_v, input int exp_v);
    n_chk++;
    if (act_v != exp_v) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act_v, exp_v);
    end
  endtask

  task automatic wr(input logic [CTRL_W-1:0] d);
    @(negedge clk);
    we = 1'b1; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic count(input int n, output int ns, output int np);
    ns = 0; np = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ns += int'(sns_en); np += int'(pix_en);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 out_en", int'(oe), 1);
    check("R1 soft_rst", int'(srst), 0);
    check("R1 pending", int'(pend), 0);
    check("R1 active", int'(act), 0);
    check("R1 addr", int'(addr), 'h49);
  endtask

  task automatic t_clocks();
    int ns, np;
    count(8, ns, np);
    check("R3 sns full rate", ns, 8);
    check("R4 pix half rate", np, 4);
    wr(16'h0008);
    count(8, ns, np);
    check("R3 sns halved", ns, 4);
    check("R4 pix halved", np, 2);
    wr(16'h0002);
    count(8, ns, np);
    check("R5 pipe off pix", np, 0);
    check("R5 pipe off sns", ns, 8);
    wr(16'h0000);
  endtask

  task automatic t_soft_reset();
    wr(16'h0418);
    check("R9 odis", int'(oe), 0);
    check("R10 flip", int'(addr), 'h48);
    wr(16'h0001);
    check("R2 pulse high", int'(srst), 1);
    check("R2 odis cleared", int'(oe), 1);
    check("R2 flip cleared", int'(addr), 'h49);
    @(negedge clk);
    check("R2 pulse one cycle", int'(srst), 0);
    begin
      int ns, np;
      count(8, ns, np);
      check("R2 div cleared", ns, 8);
    end
  endtask

  task automatic t_soft_stby();
    wr(16'h0004);
    @(negedge clk);
    check("R6 soft pending", int'(pend), 1);
    check("R9 soft stby keeps oe", int'(oe), 1);
    check("R6 clocks run while pending", int'(sns_en), 1);
    wr(16'h0000);
    @(negedge clk);
    check("R7 cancel pending", int'(pend), 0);
    check("R7 no standby", int'(act), 0);
  endtask

  task automatic t_pin_stby();
    @(negedge clk);
    pin = 1'b1;
    @(negedge clk);
    check("R11 one edge", int'(oe), 1);
    @(negedge clk);
    check("R9 pin tristate", int'(oe), 0);
    check("R11 fsm not yet", int'(pend), 0);
    @(negedge clk);
    check("R11 pending third edge", int'(pend), 1);
    repeat (3) @(negedge clk);
    check("R6 waits for row", int'(act), 0);
    row_done = 1'b1;
    @(negedge clk);
    row_done = 1'b0;
    check("R6 active", int'(act), 1);
    check("R6 sns gated", int'(sns_en), 0);
    check("R6 pix gated", int'(pix_en), 0);
    wr(16'h0440);
    check("R9 drive bit", int'(oe), 1);
    check("R10 flip locked", int'(addr), 'h49);
    pin = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 still active", int'(act), 1);
    @(negedge clk);
    check("R8 exit", int'(act), 0);
    check("R8 clocks resume", int'(sns_en), 1);
    wr(16'h0400);
    check("R10 flip unlocked", int'(addr), 'h48);
    strap = 1'b0;
    @(negedge clk);
    check("R10 strap xor", int'(addr), 'h49);
    strap = 1'b1;
    wr(16'h0000);
  endtask

  initial begin
    t_reset();
    t_clocks();
    t_soft_reset();
    t_soft_stby();
    t_pin_stby();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule